// File: doc/BRIEF.md
# Split-Nibble Clock Divider

This block turns a fast base clock into a slower clock-enable waveform for a memory-card interface. An 8-bit divide field holds two 4-bit counts: the high nibble gives the number of base cycles minus one that the output stays high, and the low nibble gives the same for the low phase. The output period is therefore the sum of both lengths, and odd ratios come with at most one cycle of duty skew. A 16-bit control register holds this field, two path-select bits and six spare bits. It is written through a small operation port that can write the whole word, write only the divide field, or switch between the card path and the stick path.

A new divide setting is taken only when a low phase ends. Each period therefore finishes with the lengths it started with, and no short pulse appears. When the system runs at its low-power performance level, the divider is held and the output copies a slow reference enable instead. A running flag shows whether the divided waveform is on the output.

Top module: `split_nibble_clkdiv`

## Requirements
- R1: While `rst` is high, each clock edge sets `ctrl_q` to 0x0054 and drives `div_clk`, `div_tick` and `running` low.
- R2: `div_clk` goes high on the first edge after reset is released. It then stays high for H+1 base cycles and low for L+1 base cycles, where H is `ctrl_q[7:4]` and L is `ctrl_q[3:0]` (0x54 gives 6 high, 5 low).
- R3: A divide field of 0x00 gives one cycle high and one cycle low, alternating.
- R4: Operation code 2 (divide write) changes only `ctrl_q[7:0]`, and only when the value is accepted. Bits 15..8 stay as they were.
- R5: A divide value is accepted only if H <= 5, L <= 4, and either H equals L or H equals L+1 with L > 0. That is, only 0x00, 0x11, 0x21, 0x22, 0x32, 0x33, 0x43, 0x44 and 0x54. A rejected value leaves the field and the waveform unchanged.
- R6: A divide value written during a period takes effect only at the next rising edge of `div_clk` after the current low phase ends.
- R7: While `low_power` is high, `div_clk` equals `ref_in` delayed by one cycle, and `running` and `div_tick` are low. After `low_power` falls, a high phase starts on the next edge.
- R8: Operation code 3 (path set) clears `ctrl_q[8]` (feedback select) and sets `ctrl_q[9]` (stick select) to `cfg_wdata[0]`. While bit 9 is set, the divider uses the fixed stick setting, which defaults to 0x22.
- R9: Operation code 1 (full write) loads all 16 bits of `cfg_wdata` into `ctrl_q`, but keeps the old divide field if the new one is rejected under R5.
- R10: `div_tick` is high exactly in the first high cycle of each divided period, and never in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_op | input | 2 | Operation: 0 none, 1 full write, 2 divide write, 3 path set |
| cfg_wdata | input | 16 | Write data for the operation |
| low_power | input | 1 | Low-power performance level; selects bypass |
| ref_in | input | 1 | Slow reference enable used in bypass |
| div_clk | output | 1 | Registered divided clock-enable waveform |
| div_tick | output | 1 | Pulse in the first high cycle of each period |
| running | output | 1 | High when the divided waveform is on the output |
| ctrl_q | output | 16 | Control register contents |

## Verification
The checker tests several rules on every cycle:
- the reset values;
- that a divide write leaves the upper byte alone and a rejected value leaves the register alone;
- the path-set bit results;
- that bypass copies the delayed reference with the running flag low;
- that a tick only appears during a high running cycle;
- that no high phase runs past the longest accepted length.

The exact phase lengths for each setting, the deferral of a new value to the end of a low phase, the stick setting taking over, and the restart after bypass and after a mid-run reset can only be shown by the bench. It does this by comparing every output cycle against a waveform it predicts itself.

// File: rtl/snd_pkg.sv
package snd_pkg;

    localparam int CTRL_W   = 16;
    localparam int NIB_W    = 4;
    localparam int DIV_W    = 2 * NIB_W;
    localparam int SPARE_W  = CTRL_W - DIV_W - 2;
    localparam int MAX_HI   = 5;
    localparam int MAX_LO   = 4;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_WRITE_ALL = 2'd1,
        OP_WRITE_DIV = 2'd2,
        OP_SET_PATH  = 2'd3
    } cfg_op_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } div_set_t;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic               stick;
        logic               fb;
        div_set_t           div;
    } ctrl_t;

    // Accepted settings: balanced or high-heavy by one, within the limits.
    function automatic logic div_ok(div_set_t d);
        logic in_range;
        logic balanced;
        logic skewed;
        in_range = (int'(d.hi) <= MAX_HI) && (int'(d.lo) <= MAX_LO);
        balanced = (d.hi == d.lo);
        skewed   = (d.lo != '0) && (d.hi == d.lo + NIB_W'(1));
        return in_range && (balanced || skewed);
    endfunction

endpackage

// File: rtl/snd_ctrl_reg.sv
module snd_ctrl_reg
    import snd_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_CTRL = 16'h0054
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_op,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output ctrl_t             ctrl_q
);

    ctrl_t    ctrl_d;
    ctrl_t    wr_word;
    div_set_t wr_div;

    assign wr_word = ctrl_t'(cfg_wdata);
    assign wr_div  = div_set_t'(cfg_wdata[DIV_W-1:0]);

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (cfg_op_e'(cfg_op))
            OP_WRITE_ALL: begin
                ctrl_d = wr_word;
                if (!div_ok(wr_word.div)) begin
                    ctrl_d.div = ctrl_q.div;
                end
            end
            OP_WRITE_DIV: begin
                if (div_ok(wr_div)) begin
                    ctrl_d.div = wr_div;
                end
            end
            OP_SET_PATH: begin
                ctrl_d.fb    = 1'b0;
                ctrl_d.stick = cfg_wdata[0];
            end
            default: ctrl_d = ctrl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(RESET_CTRL);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/snd_phase_gen.sv
module snd_phase_gen
    import snd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  div_set_t next_set,
    output logic     hi_next,
    output logic     enter_hi
);

    phase_e           phase_q, phase_d;
    logic [NIB_W-1:0] cnt_q, cnt_d;
    div_set_t         act_q, act_d;

    // Reset and hold both park the generator at the end of a low phase,
    // so the next free-running edge always opens a high phase.
    always_comb begin
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        act_d    = act_q;
        enter_hi = 1'b0;
        if (hold) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
        end else if (phase_q == PH_HIGH) begin
            if (cnt_q == '0) begin
                phase_d = PH_LOW;
                cnt_d   = act_q.lo;
            end else begin
                cnt_d = cnt_q - NIB_W'(1);
            end
        end else begin
            if (cnt_q == '0) begin
                act_d    = next_set;
                phase_d  = PH_HIGH;
                cnt_d    = next_set.hi;
                enter_hi = 1'b1;
            end else begin
                cnt_d = cnt_q - NIB_W'(1);
            end
        end
    end

    assign hi_next = (phase_d == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

endmodule

// File: rtl/snd_out_stage.sv
module snd_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic ref_in,
    input  logic hi_next,
    input  logic enter_hi,
    output logic div_clk,
    output logic div_tick,
    output logic running
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_clk  <= 1'b0;
            div_tick <= 1'b0;
            running  <= 1'b0;
        end else if (bypass) begin
            div_clk  <= ref_in;
            div_tick <= 1'b0;
            running  <= 1'b0;
        end else begin
            div_clk  <= hi_next;
            div_tick <= enter_hi;
            running  <= 1'b1;
        end
    end

endmodule

// File: rtl/split_nibble_clkdiv.sv
module split_nibble_clkdiv
    import snd_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_CTRL = 16'h0054,
    parameter logic [DIV_W-1:0]  STICK_DIV  = 8'h22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_op,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              low_power,
    input  logic              ref_in,
    output logic              div_clk,
    output logic              div_tick,
    output logic              running,
    output logic [CTRL_W-1:0] ctrl_q
);

    ctrl_t    ctrl;
    div_set_t eff_set;
    logic     hi_next;
    logic     enter_hi;

    snd_ctrl_reg #(.RESET_CTRL(RESET_CTRL)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_op    (cfg_op),
        .cfg_wdata (cfg_wdata),
        .ctrl_q    (ctrl)
    );

    always_comb begin
        eff_set = ctrl.stick ? div_set_t'(STICK_DIV) : ctrl.div;
    end

    snd_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .hold     (low_power),
        .next_set (eff_set),
        .hi_next  (hi_next),
        .enter_hi (enter_hi)
    );

    snd_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .bypass   (low_power),
        .ref_in   (ref_in),
        .hi_next  (hi_next),
        .enter_hi (enter_hi),
        .div_clk  (div_clk),
        .div_tick (div_tick),
        .running  (running)
    );

    assign ctrl_q = ctrl_q_w(ctrl);

    function automatic logic [CTRL_W-1:0] ctrl_q_w(ctrl_t c);
        return CTRL_W'(c);
    endfunction

endmodule

// File: rtl/snd_checker.sv
module snd_checker
    import snd_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_CTRL = 16'h0054
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cfg_op,
    input logic [CTRL_W-1:0] cfg_wdata,
    input logic              low_power,
    input logic              ref_in,
    input logic              div_clk,
    input logic              div_tick,
    input logic              running,
    input logic [CTRL_W-1:0] ctrl_q
);

    logic [NIB_W:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst || !div_clk || !running) begin
            hi_run <= '0;
        end else begin
            hi_run <= hi_run + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == RESET_CTRL && !div_clk && !div_tick && !running));

    assert_high_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        (div_clk && running) |-> (int'(hi_run) <= MAX_HI));

    assert_div_write_keeps_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_op == 2'd2) |=> (ctrl_q[CTRL_W-1:DIV_W] == $past(ctrl_q[CTRL_W-1:DIV_W])));

    assert_reject_unsupported_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_op == 2'd2 && !div_ok(div_set_t'(cfg_wdata[DIV_W-1:0]))) |=> $stable(ctrl_q));

    assert_bypass_follows_ref_R7: assert property (@(posedge clk) disable iff (rst)
        low_power |=> (div_clk == $past(ref_in) && !running && !div_tick));

    assert_path_set_bits_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_op == 2'd3) |=> (!ctrl_q[DIV_W] && ctrl_q[DIV_W+1] == $past(cfg_wdata[0])));

    assert_tick_in_high_R10: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> (div_clk && running));

endmodule

bind split_nibble_clkdiv snd_checker #(.RESET_CTRL(RESET_CTRL)) u_snd_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_op    (cfg_op),
    .cfg_wdata (cfg_wdata),
    .low_power (low_power),
    .ref_in    (ref_in),
    .div_clk   (div_clk),
    .div_tick  (div_tick),
    .running   (running),
    .ctrl_q    (ctrl_q)
);

// File: tb/split_nibble_clkdiv_test.sv
module split_nibble_clkdiv_test;
    import snd_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_op;
    logic [15:0] cfg_wdata;
    logic        low_power;
    logic        ref_in;
    logic        div_clk;
    logic        div_tick;
    logic        running;
    logic [15:0] ctrl_q;

    always #4 clk = ~clk;

    split_nibble_clkdiv uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_op    (cfg_op),
        .cfg_wdata (cfg_wdata),
        .low_power (low_power),
        .ref_in    (ref_in),
        .div_clk   (div_clk),
        .div_tick  (div_tick),
        .running   (running),
        .ctrl_q    (ctrl_q)
    );

    typedef struct {
        int unsigned at;
        logic        clk_v;
        logic        tick_v;
        logic        run_v;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int unsigned next_start = 0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_periods(int n, int hi, int lo, string req);
        int unsigned k;
        exp_t e;
        k = next_start;
        for (int p = 0; p < n; p++) begin
            for (int i = 0; i <= hi; i++) begin
                e.at = k; e.clk_v = 1'b1; e.tick_v = (i == 0); e.run_v = 1'b1; e.req = req;
                sb.push_back(e);
                k++;
            end
            for (int i = 0; i <= lo; i++) begin
                e.at = k; e.clk_v = 1'b0; e.tick_v = 1'b0; e.run_v = 1'b1; e.req = req;
                sb.push_back(e);
                k++;
            end
        end
        next_start = k;
    endtask

    task automatic wait_cyc(int unsigned t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_op(cfg_op_e op, logic [15:0] data);
        cfg_op    = op;
        cfg_wdata = data;
        @(posedge clk);
        #1;
        cfg_op    = OP_NONE;
        cfg_wdata = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: pops scoreboard items whose cycle has come and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.at < cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL %s stale item actual=%0d expected=%0d", e.req, cyc, e.at);
                end else begin
                    check(e.req, "div_clk", 32'(div_clk), 32'(e.clk_v));
                    check(e.req, "div_tick", 32'(div_tick), 32'(e.tick_v));
                    check(e.req, "running", 32'(running), 32'(e.run_v));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        pat       = 8'b1011_0100;
        rst       = 1'b1;
        cfg_op    = OP_NONE;
        cfg_wdata = '0;
        low_power = 1'b0;
        ref_in    = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "ctrl_q", 32'(ctrl_q), 32'h0054);
        check("R1", "div_clk", 32'(div_clk), 32'h0);
        check("R1", "running", 32'(running), 32'h0);
        check("R1", "div_tick", 32'(div_tick), 32'h0);

        // R2: default 6 high / 5 low from the first edge after release
        rst = 1'b0;
        next_start = cyc + 1;
        push_periods(2, 5, 4, "R2");
        push_periods(1, 5, 4, "R6");
        // R6: write in the high phase of the last period; that period keeps 0x54
        wait_cyc(next_start - 10);
        do_op(OP_WRITE_DIV, 16'hFF00);
        check("R4", "ctrl_q", 32'(ctrl_q), 32'h0000);
        // R3: divide by two
        push_periods(4, 0, 0, "R3");

        // R9: full write
        wait_cyc(next_start - 2);
        do_op(OP_WRITE_ALL, 16'hA433);
        check("R9", "ctrl_q", 32'(ctrl_q), 32'hA433);
        push_periods(2, 3, 3, "R9");

        // R5: rejected values leave register and waveform unchanged
        wait_cyc(next_start - 6);
        do_op(OP_WRITE_DIV, 16'h0055);
        check("R5", "ctrl_q", 32'(ctrl_q), 32'hA433);
        do_op(OP_WRITE_DIV, 16'h0010);
        check("R5", "ctrl_q", 32'(ctrl_q), 32'hA433);
        push_periods(1, 3, 3, "R5");

        // R4: divide write keeps upper byte, odd ratio 3 high / 2 low
        wait_cyc(next_start - 4);
        do_op(OP_WRITE_DIV, 16'h1221);
        check("R4", "ctrl_q", 32'(ctrl_q), 32'hA421);
        push_periods(2, 2, 1, "R4");

        // R8: stick path uses fixed 0x22 setting
        wait_cyc(next_start - 3);
        do_op(OP_SET_PATH, 16'h0001);
        check("R8", "ctrl_q", 32'(ctrl_q), 32'hA621);
        push_periods(2, 2, 2, "R8");
        wait_cyc(next_start - 3);
        do_op(OP_WRITE_ALL, 16'h0343);
        check("R9", "ctrl_q", 32'(ctrl_q), 32'h0343);
        push_periods(1, 2, 2, "R8");
        wait_cyc(next_start - 3);
        do_op(OP_SET_PATH, 16'h0000);
        check("R8", "ctrl_q", 32'(ctrl_q), 32'h0043);
        push_periods(2, 4, 3, "R8");

        // R7: low-power bypass follows the reference
        wait_cyc(next_start - 1);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            low_power = 1'b1;
            ref_in    = pat[i];
            e.at = cyc + 1; e.clk_v = pat[i]; e.tick_v = 1'b0; e.run_v = 1'b0; e.req = "R7";
            sb.push_back(e);
            @(posedge clk);
            #1;
        end
        low_power = 1'b0;
        ref_in    = 1'b0;
        next_start = cyc + 1;
        push_periods(2, 4, 3, "R7");

        // R1: reset in the middle of a run, then restart with the default
        wait_cyc(next_start - 1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "ctrl_q", 32'(ctrl_q), 32'h0054);
        check("R1", "div_clk", 32'(div_clk), 32'h0);
        check("R1", "running", 32'(running), 32'h0);
        rst = 1'b0;
        next_start = cyc + 1;
        push_periods(1, 5, 4, "R1");
        wait_cyc(next_start + 1);
        // R10 is covered by the tick comparison on every scoreboard item
        check("R10", "queue_empty", 32'(sb.size()), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule